// File: doc/BRIEF.md
# Debug Breakpoint Trigger Unit

This block sits beside a processor core and watches three streams: the address and data of each bus transfer, and the program counter of each executed instruction. Software loads six breakpoint registers and one configuration word through a write port: a low and a high address bound, a data reference with its mask, and a PC reference with its mask. Each cycle the block compares the live values against these references. It then combines the results of the enabled comparisons into a trigger condition.

A trigger can be single-level, where one matching condition fires the action. It can also be two-level, where a first condition only arms the unit and a second condition, seen in a later cycle, fires it. When a trigger fires, the block raises a one-cycle request to halt the core or a one-cycle request for a debug interrupt, as the configuration selects. A software clear input drops the armed state.

Top module: `dbg_trig_unit`

## Requirements
- R1: After reset, `halt_req`, `dbg_irq` and `armed` are 0, and all breakpoint and configuration registers hold 0, so no condition is enabled.
- R2: A write with `wr_en`=1 loads `wr_data` into the register picked by `wr_sel`: 0 address low bound, 1 address high bound, 2 data reference, 3 data mask, 4 PC reference, 5 PC mask, 6 configuration. Select 7 is ignored.
- R3: The address condition holds on a cycle with `bus_valid`=1 when low <= `bus_addr` <= high, with both bounds inclusive and configuration bit 6 clear.
- R4: With configuration bit 6 set, the address condition holds instead when `bus_addr` lies outside that inclusive range and `bus_valid`=1.
- R5: The data condition holds when `bus_valid`=1 and ((`bus_data` ^ reference) & ~mask) == 0. A mask bit of 1 excludes that bit. On cycles with `bus_valid`=0 the condition never holds.
- R6: The PC condition holds when `insn_valid`=1 and ((`insn_pc` ^ reference) & ~mask) == 0. On cycles with `insn_valid`=0 it never holds.
- R7: A level matches when all of its enabled conditions hold and at least one condition is enabled. Level-1 enables are configuration bits 0 (address), 1 (data) and 2 (PC). Level-2 enables are bits 3, 4 and 5, in the same order. A disabled condition takes no part.
- R8: With configuration bit 7 clear, a level-1 match fires the action. With bit 7 set, a level-1 match sets `armed` and fires nothing. The action fires on the first later cycle in which `armed` is 1 and level 2 matches. A level-2 match in the same cycle as the arming match does not fire.
- R9: `armed` clears on the edge at which the action fires and on the edge after `soft_clr`=1. Once it is cleared, a level-2 match fires nothing.
- R10: A firing asserts for exactly one cycle, on the clock edge after the matching inputs. It asserts `halt_req` when configuration bit 8 is 0 and `dbg_irq` when bit 8 is 1. Both never assert together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for a write |
| wr_data | input | 32 | Write data |
| soft_clr | input | 1 | Clears the armed state |
| bus_valid | input | 1 | A bus transfer is present this cycle |
| bus_addr | input | 32 | Transfer address |
| bus_data | input | 32 | Transfer data |
| insn_valid | input | 1 | An instruction is present this cycle |
| insn_pc | input | 32 | Instruction program counter |
| halt_req | output | 1 | One-cycle halt request |
| dbg_irq | output | 1 | One-cycle debug interrupt request |
| armed | output | 1 | Level 1 of a two-level trigger has matched |

## Verification
The comparisons are combinational and the outputs are registered. A request that stems from inputs driven before a rising edge therefore appears right after that edge. The bench drives stimulus on a falling edge and samples at the next falling edge. The same edge updates `armed`, so the same sample also checks arming and clearing. A register write takes effect at the edge that captures it, so every configuration write is followed by stimulus only from the next falling edge onward. The one-cycle length of a request is checked by sampling again one more falling edge later, with the inputs idle.

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [31:0]   wr_data,
  input  logic          soft_clr,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic          insn_valid,
  input  logic [AW-1:0] insn_pc,
  output logic          halt_req,
  output logic          dbg_irq,
  output logic          armed
);
  localparam int CW = 9;

  logic [AW-1:0] addr_lo, addr_hi, pc_ref, pc_msk;
  logic [DW-1:0] data_ref, data_msk;
  logic [CW-1:0] ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_lo <= '0; addr_hi <= '0; pc_ref <= '0; pc_msk <= '0;
      data_ref <= '0; data_msk <= '0; ctrl <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        3'd0: addr_lo  <= wr_data[AW-1:0];
        3'd1: addr_hi  <= wr_data[AW-1:0];
        3'd2: data_ref <= wr_data[DW-1:0];
        3'd3: data_msk <= wr_data[DW-1:0];
        3'd4: pc_ref   <= wr_data[AW-1:0];
        3'd5: pc_msk   <= wr_data[AW-1:0];
        3'd6: ctrl     <= wr_data[CW-1:0];
        default: ;
      endcase
    end
  end

  wire in_rng = (bus_addr >= addr_lo) && (bus_addr <= addr_hi);
  wire m_addr = bus_valid && (in_rng ^ ctrl[6]);
  wire m_data = bus_valid && (((bus_data ^ data_ref) & ~data_msk) == '0);
  wire m_pc   = insn_valid && (((insn_pc ^ pc_ref) & ~pc_msk) == '0);
  wire [2:0] hits = {m_pc, m_data, m_addr};

  wire lvl1 = (|ctrl[2:0]) && ((hits | ~ctrl[2:0]) == 3'b111);
  wire lvl2 = (|ctrl[5:3]) && ((hits | ~ctrl[5:3]) == 3'b111);
  wire dual = ctrl[7];
  wire fire = dual ? (armed && lvl2) : lvl1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; halt_req <= 1'b0; dbg_irq <= 1'b0;
    end else begin
      halt_req <= fire && !ctrl[8];
      dbg_irq  <= fire && ctrl[8];
      if (soft_clr || fire) armed <= 1'b0;
      else if (dual && lvl1) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/dbg_trig_unit_chk.sv
module dbg_trig_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_clr,
  input logic       halt_req,
  input logic       dbg_irq,
  input logic       armed,
  input logic [8:0] ctrl
);
  p_one_action_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({halt_req, dbg_irq}));
  p_halt_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> !$past(ctrl[8]));
  p_irq_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_irq |-> $past(ctrl[8]));
  p_soft_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> !armed);
  p_fire_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req || dbg_irq) |-> !armed);
  p_dual_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl[7]) && (halt_req || dbg_irq)) |-> $past(armed));
  p_no_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[2:0] == 3'b000 && !ctrl[7]) |=> !(halt_req || dbg_irq));
endmodule

bind dbg_trig_unit dbg_trig_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .halt_req(halt_req),
  .dbg_irq(dbg_irq), .armed(armed), .ctrl(ctrl)
);

// File: tb/dbg_trig_unit_tb.sv
module dbg_trig_unit_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, soft_clr = 1'b0, bus_valid = 1'b0, insn_valid = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [31:0] wr_data = '0, bus_addr = '0, bus_data = '0, insn_pc = '0;
  logic halt_req, dbg_irq, armed;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  dbg_trig_unit u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .soft_clr(soft_clr), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_data(bus_data), .insn_valid(insn_valid), .insn_pc(insn_pc),
    .halt_req(halt_req), .dbg_irq(dbg_irq), .armed(armed)
  );

  typedef struct packed {
    logic [8:0]  ctrl;
    logic        bv;
    logic [31:0] addr;
    logic [31:0] data;
    logic        iv;
    logic [31:0] pc;
    logic        eh;
    logic        ei;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{9'h001, 1'b1, 32'h1000, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0},           // R3 low bound
    '{9'h001, 1'b1, 32'h1FFF, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0},           // R3 high bound
    '{9'h001, 1'b1, 32'h0FFF, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0},           // R3 below
    '{9'h001, 1'b1, 32'h2000, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0},           // R3 above
    '{9'h001, 1'b0, 32'h1800, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0},           // R3 no transfer
    '{9'h041, 1'b1, 32'h2000, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0},           // R4 outside hit
    '{9'h041, 1'b1, 32'h1800, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0},           // R4 inside miss
    '{9'h002, 1'b1, 32'h0, 32'hA5A5_1234, 1'b0, 32'h0, 1'b1, 1'b0},      // R5 masked hit
    '{9'h002, 1'b1, 32'h0, 32'hA5A4_0000, 1'b0, 32'h0, 1'b0, 1'b0},      // R5 miss
    '{9'h002, 1'b0, 32'h0, 32'hA5A5_0000, 1'b0, 32'h0, 1'b0, 1'b0},      // R5 no transfer
    '{9'h004, 1'b0, 32'h0, 32'h0, 1'b1, 32'h4077, 1'b1, 1'b0},           // R6 masked hit
    '{9'h004, 1'b0, 32'h0, 32'h0, 1'b1, 32'h4177, 1'b0, 1'b0},           // R6 miss
    '{9'h004, 1'b0, 32'h0, 32'h0, 1'b0, 32'h4000, 1'b0, 1'b0},           // R6 no insn
    '{9'h105, 1'b1, 32'h1234, 32'h0, 1'b1, 32'h4001, 1'b0, 1'b1},        // R7 addr+pc, R10 irq
    '{9'h005, 1'b1, 32'h1234, 32'h0, 1'b1, 32'h5001, 1'b0, 1'b0},        // R7 pc misses
    '{9'h000, 1'b1, 32'h1234, 32'hA5A5_0000, 1'b1, 32'h4000, 1'b0, 1'b0},// R7 none enabled
    '{9'h106, 1'b1, 32'h0, 32'hA5A5_FFFF, 1'b1, 32'h40FF, 1'b0, 1'b1}    // R7 data+pc
  };

  task automatic chk(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drive(input logic bv, input logic [31:0] a, input logic [31:0] d,
                       input logic iv, input logic [31:0] p);
    bus_valid = bv; bus_addr = a; bus_data = d; insn_valid = iv; insn_pc = p;
    @(negedge clk);
    bus_valid = 1'b0; insn_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 halt_req", halt_req, 1'b0);
    chk("R1 dbg_irq", dbg_irq, 1'b0);
    chk("R1 armed", armed, 1'b0);
    drive(1'b1, 32'h0, 32'h0, 1'b1, 32'h0);
    chk("R1 zero regs never fire", halt_req | dbg_irq, 1'b0);

    wr(3'd0, 32'h1000); wr(3'd1, 32'h1FFF);
    wr(3'd2, 32'hA5A5_0000); wr(3'd3, 32'h0000_FFFF);
    wr(3'd4, 32'h0000_4000); wr(3'd5, 32'h0000_00FF);
    wr(3'd7, 32'hFFFF_FFFF);

    for (int i = 0; i < NV; i++) begin
      wr(3'd6, {23'd0, TBL[i].ctrl});
      drive(TBL[i].bv, TBL[i].addr, TBL[i].data, TBL[i].iv, TBL[i].pc);
      chk($sformatf("R2/R10 vec %0d halt_req", i), halt_req, TBL[i].eh);
      chk($sformatf("R2/R10 vec %0d dbg_irq", i), dbg_irq, TBL[i].ei);
      @(negedge clk);
      chk($sformatf("R10 vec %0d pulse ends", i), halt_req | dbg_irq, 1'b0);
    end

    // dual-level: L1 = address, L2 = PC, interrupt action
    wr(3'd6, 32'h1A1);
    drive(1'b1, 32'h1500, 32'h0, 1'b0, 32'h0);
    chk("R8 arming fires nothing", halt_req | dbg_irq, 1'b0);
    chk("R8 armed set", armed, 1'b1);
    drive(1'b0, 32'h0, 32'h0, 1'b0, 32'h0);
    chk("R8 armed held", armed, 1'b1);
    drive(1'b0, 32'h0, 32'h0, 1'b1, 32'h4010);
    chk("R8 level 2 fires irq", dbg_irq, 1'b1);
    chk("R10 no halt with irq", halt_req, 1'b0);
    chk("R9 armed cleared on fire", armed, 1'b0);
    drive(1'b0, 32'h0, 32'h0, 1'b1, 32'h4010);
    chk("R9 level 2 after clear fires nothing", dbg_irq | halt_req, 1'b0);

    // same-cycle L1 and L2 only arms
    drive(1'b1, 32'h1500, 32'h0, 1'b1, 32'h4010);
    chk("R8 same cycle does not fire", dbg_irq | halt_req, 1'b0);
    chk("R8 same cycle arms", armed, 1'b1);
    soft_clr = 1'b1;
    @(negedge clk);
    soft_clr = 1'b0;
    chk("R9 soft clear drops armed", armed, 1'b0);
    drive(1'b0, 32'h0, 32'h0, 1'b1, 32'h4010);
    chk("R9 level 2 after soft clear", dbg_irq | halt_req, 1'b0);

    // dual-level with halt action
    wr(3'd6, 32'h0A1);
    drive(1'b1, 32'h1FFF, 32'h0, 1'b0, 32'h0);
    chk("R8 re-arm", armed, 1'b1);
    drive(1'b0, 32'h0, 32'h0, 1'b1, 32'h40AA);
    chk("R10 dual halt action", halt_req, 1'b1);
    chk("R10 dual no irq", dbg_irq, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule